// File: doc/BRIEF.md
# Wake Event Signal Controller

This block turns wake events into an active-low, open-drain wake request for a host bus. Three detectors outside the block send it single-cycle pulses: a magic packet was received, the link state changed, or a wakeup frame matched. When the device-side enable is on, any of these pulses sets a sticky event status bit. Software reads the bit and clears it by writing a one to it.

The wake pin is pulled low only while the status is set and three gates are all open. The first gate is the device-side enable. The second is the enable held in the bus configuration space. The third is the support bit for the current power state. A five-bit support field lists the power states from which an event may be signalled. It is loaded from nonvolatile storage, so signalling from D0 can be turned off there.

The status and the pin are kept in a three-state machine:

- IDLE: no event is pending.
- HELD: an event is pending but a gate is closed.
- DRIVE: an event is pending and the pin is pulled low.

Transitions:

- arm-held: IDLE to HELD.
- arm-drive: IDLE to DRIVE.
- open: HELD to DRIVE.
- close: DRIVE to HELD.
- clear: HELD or DRIVE to IDLE.

Top module: `pwrevt_ctrl`

## Requirements
- R1: While `rst_n` is low, and after reset, `status_o` is 0, `wake_oe_o` is 0 and `wake_pin_o` is 1.
- R2: A pulse on any of the three event inputs sets `status_o` at the next clock edge when `dev_en_i` is 1. When `dev_en_i` is 0, events leave the status unchanged.
- R3: Once set, `status_o` stays 1 on every cycle without a clearing write, whatever the enables and power state do.
- R4: A cycle with `stat_wr_i`=1 and `stat_wdata_i`=1 clears the status at the next edge. A write with `stat_wdata_i`=0 has no effect.
- R5: When an enabled event and a clearing write fall in the same cycle, the status is 1 after the edge.
- R6: `wake_oe_o` is registered. After an edge it is 1 exactly when the status after that edge is 1 and `dev_en_i`, `bus_en_i` and the selected support bit were all 1 in the cycle before the edge. `wake_pin_o` is always the inverse of `wake_oe_o`.
- R7: `pwr_state_i` is encoded as 0=D0, 1=D1, 2=D2, 3=D3hot and 4=D3cold. It selects `support_i[pwr_state_i]`; `support_i` bit 0 through bit 4 correspond to capability bits 11 through 15. Codes 5 to 7 are never supported, and a cleared support bit (including D0) blocks the pin.
- R8: With `bus_en_i`=0 the pin is released at the next edge, but the status still sets on enabled events.
- R9: `wake_oe_o` is never 1 while `status_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_magic_i | input | 1 | Magic packet received pulse |
| evt_link_i | input | 1 | Link state change pulse |
| evt_frame_i | input | 1 | Wakeup frame match pulse |
| pwr_state_i | input | 3 | Current power state code (0=D0 … 4=D3cold) |
| support_i | input | 5 | Per-state event support bits, bit n for state code n |
| dev_en_i | input | 1 | Device-side event enable |
| bus_en_i | input | 1 | Bus configuration-side event enable |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 1 | Value written to the status bit (1 clears) |
| status_o | output | 1 | Sticky event status |
| wake_oe_o | output | 1 | Open-drain output enable, 1 pulls the pin low |
| wake_pin_o | output | 1 | Wake pin level, 0 while driven |

## Verification
An enabled event and a clearing write to the status can land in the same cycle. The sweep provokes this for every power state, support pattern and enable pair by raising an event pulse together with a write of one. It then judges the status and pin after the edge against a bench model in which the set takes priority. A second collision is a gate closing in the same cycle as an event arrives. The random phase covers this by toggling enables, state and support every cycle next to events and writes. The model expects a set status with the pin released.

// File: rtl/pwrevt_pkg.sv
package pwrevt_pkg;

    // Number of power states that carry a support bit (D0, D1, D2, D3hot, D3cold)
    localparam int NUM_PS = 5;
    localparam int PS_W   = $clog2(NUM_PS + 1);

    // Power state codes on pwr_state_i; the support bit index equals the code
    localparam logic [PS_W-1:0] PS_D0     = PS_W'(0);
    localparam logic [PS_W-1:0] PS_D1     = PS_W'(1);
    localparam logic [PS_W-1:0] PS_D2     = PS_W'(2);
    localparam logic [PS_W-1:0] PS_D3HOT  = PS_W'(3);
    localparam logic [PS_W-1:0] PS_D3COLD = PS_W'(4);

    // Number of wake event sources
    localparam int NUM_EVT = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HELD  = 2'd1,
        ST_DRIVE = 2'd2
    } wk_state_t;

endpackage

// File: rtl/pwrevt_src.sv
module pwrevt_src
    import pwrevt_pkg::*;
#(
    parameter int N_EVT = NUM_EVT
) (
    input  logic [N_EVT-1:0] evt_i,
    input  logic             dev_en_i,
    input  logic             wr_i,
    input  logic             wdata_i,
    output logic             set_o,
    output logic             clr_o
);

    // Any enabled event source asks for the status to set
    logic [N_EVT-1:0] gated;

    genvar g;
    generate
        for (g = 0; g < N_EVT; g++) begin : g_evt
            assign gated[g] = evt_i[g] & dev_en_i;
        end
    endgenerate

    always_comb begin
        set_o = |gated;
        // Only a written one clears; a written zero is ignored
        clr_o = wr_i & wdata_i;
    end

endmodule

// File: rtl/pwrevt_gate.sv
module pwrevt_gate
    import pwrevt_pkg::*;
#(
    parameter int N_PS = NUM_PS,
    parameter int SW   = PS_W
) (
    input  logic [SW-1:0]   pwr_state_i,
    input  logic [N_PS-1:0] support_i,
    input  logic            dev_en_i,
    input  logic            bus_en_i,
    output logic            open_o
);

    // One-hot decode of the state, masked by its support bit
    logic [N_PS-1:0] hit;

    genvar s;
    generate
        for (s = 0; s < N_PS; s++) begin : g_ps
            assign hit[s] = (pwr_state_i == SW'(s)) & support_i[s];
        end
    endgenerate

    // Codes beyond N_PS-1 never match, so those states never signal
    always_comb begin
        open_o = dev_en_i & bus_en_i & (|hit);
    end

endmodule

// File: rtl/pwrevt_fsm.sv
module pwrevt_fsm
    import pwrevt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic open_i,
    output logic status_o,
    output logic oe_o
);

    wk_state_t state_q, state_d;
    logic      drop;

    // A clear takes effect only when no new event arrives in the same cycle
    assign drop = clr_i & ~set_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (set_i) begin
                    state_d = open_i ? ST_DRIVE : ST_HELD;   // arm-drive / arm-held
                end
            end
            ST_HELD: begin
                if (drop) begin
                    state_d = ST_IDLE;                       // clear
                end else if (open_i) begin
                    state_d = ST_DRIVE;                      // open
                end
            end
            ST_DRIVE: begin
                if (drop) begin
                    state_d = ST_IDLE;                       // clear
                end else if (!open_i) begin
                    state_d = ST_HELD;                       // close
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        status_o = (state_q != ST_IDLE);
        oe_o     = (state_q == ST_DRIVE);
    end

endmodule

// File: rtl/pwrevt_ctrl.sv
module pwrevt_ctrl
    import pwrevt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            evt_magic_i,
    input  logic            evt_link_i,
    input  logic            evt_frame_i,
    input  logic [PS_W-1:0] pwr_state_i,
    input  logic [NUM_PS-1:0] support_i,
    input  logic            dev_en_i,
    input  logic            bus_en_i,
    input  logic            stat_wr_i,
    input  logic            stat_wdata_i,
    output logic            status_o,
    output logic            wake_oe_o,
    output logic            wake_pin_o
);

    logic [NUM_EVT-1:0] evt_vec;
    logic               set_w;
    logic               clr_w;
    logic               open_w;

    assign evt_vec = {evt_frame_i, evt_link_i, evt_magic_i};

    pwrevt_src #(
        .N_EVT (NUM_EVT)
    ) src_i (
        .evt_i    (evt_vec),
        .dev_en_i (dev_en_i),
        .wr_i     (stat_wr_i),
        .wdata_i  (stat_wdata_i),
        .set_o    (set_w),
        .clr_o    (clr_w)
    );

    pwrevt_gate #(
        .N_PS (NUM_PS),
        .SW   (PS_W)
    ) gate_i (
        .pwr_state_i (pwr_state_i),
        .support_i   (support_i),
        .dev_en_i    (dev_en_i),
        .bus_en_i    (bus_en_i),
        .open_o      (open_w)
    );

    pwrevt_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_w),
        .clr_i    (clr_w),
        .open_i   (open_w),
        .status_o (status_o),
        .oe_o     (wake_oe_o)
    );

    // Open-drain: the pin reads low only while it is driven
    assign wake_pin_o = ~wake_oe_o;

endmodule

// File: rtl/pwrevt_chk.sv
module pwrevt_chk
    import pwrevt_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            evt_magic_i,
    input logic            evt_link_i,
    input logic            evt_frame_i,
    input logic [PS_W-1:0] pwr_state_i,
    input logic            dev_en_i,
    input logic            bus_en_i,
    input logic            stat_wr_i,
    input logic            stat_wdata_i,
    input logic            status_o,
    input logic            wake_oe_o
);

    logic any_evt;
    logic wr_one;
    assign any_evt = dev_en_i & (evt_magic_i | evt_link_i | evt_frame_i);
    assign wr_one  = stat_wr_i & stat_wdata_i;

    AST_DRIVE_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_oe_o |-> status_o);                                         // R9
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        any_evt |=> status_o);                                           // R2
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (any_evt && wr_one) |=> status_o);                               // R5
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !wr_one) |=> status_o);                             // R3
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_one && !any_evt) |=> !status_o);                             // R4
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o && !any_evt) |=> !status_o);                          // R2
    AST_BUS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en_i |=> !wake_oe_o);                                       // R8
    AST_BAD_STATE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state_i > PS_D3COLD) |=> !wake_oe_o);                       // R7

endmodule

bind pwrevt_ctrl pwrevt_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_magic_i  (evt_magic_i),
    .evt_link_i   (evt_link_i),
    .evt_frame_i  (evt_frame_i),
    .pwr_state_i  (pwr_state_i),
    .dev_en_i     (dev_en_i),
    .bus_en_i     (bus_en_i),
    .stat_wr_i    (stat_wr_i),
    .stat_wdata_i (stat_wdata_i),
    .status_o     (status_o),
    .wake_oe_o    (wake_oe_o)
);

// File: tb/pwrevt_ctrl_tb_top.sv
module pwrevt_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       evt_magic, evt_link, evt_frame;
    logic [2:0] pwr_state;
    logic [4:0] support;
    logic       dev_en, bus_en, stat_wr, stat_wdata;
    logic       status_o, wake_oe_o, wake_pin_o;

    int checks = 0;
    int fails  = 0;

    // Bench model state
    logic m_stat = 1'b0;
    logic m_oe   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pwrevt_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_magic_i  (evt_magic),
        .evt_link_i   (evt_link),
        .evt_frame_i  (evt_frame),
        .pwr_state_i  (pwr_state),
        .support_i    (support),
        .dev_en_i     (dev_en),
        .bus_en_i     (bus_en),
        .stat_wr_i    (stat_wr),
        .stat_wdata_i (stat_wdata),
        .status_o     (status_o),
        .wake_oe_o    (wake_oe_o),
        .wake_pin_o   (wake_pin_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (state=%0d sup=%b de=%b be=%b)",
                     req, act, exp, pwr_state, support, dev_en, bus_en);
        end
    endtask

    task automatic quiet();
        evt_magic = 0; evt_link = 0; evt_frame = 0;
        stat_wr = 0; stat_wdata = 0;
    endtask

    // One clock: model update at the edge, then compare outputs
    task automatic tick(input string req);
        logic set, clr, sup_ok, open;
        @(posedge clk);
        set    = dev_en & (evt_magic | evt_link | evt_frame);
        clr    = stat_wr & stat_wdata;
        sup_ok = (pwr_state < 3'd5) ? support[pwr_state] : 1'b0;
        open   = dev_en & bus_en & sup_ok;
        m_stat = set | (m_stat & ~clr);
        m_oe   = m_stat & open;
        #1;
        check({req, " status"}, status_o, m_stat);
        check({req, " oe R6"}, wake_oe_o, m_oe);
        check({req, " pin R6"}, wake_pin_o, ~m_oe);
    endtask

    task automatic pulse_event(input int which);
        evt_magic = (which == 0);
        evt_link  = (which == 1);
        evt_frame = (which == 2);
    endtask

    initial begin
        #(4 * 190000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0; quiet();
        pwr_state = 3'd0; support = 5'h1f; dev_en = 1; bus_en = 1;
        pulse_event(0);   // events during reset must not matter
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset status", status_o, 1'b0);
        check("R1 reset oe", wake_oe_o, 1'b0);
        check("R1 reset pin", wake_pin_o, 1'b1);
        quiet();
        @(negedge clk);
        rst_n = 1;
        tick("R1 after reset");

        // Exhaustive sweep over state code, support field and enables
        for (int st = 0; st < 8; st++) begin
            for (int sp = 0; sp < 32; sp++) begin
                for (int en = 0; en < 4; en++) begin
                    pwr_state = 3'(st); support = 5'(sp);
                    dev_en = en[0]; bus_en = en[1];
                    quiet(); stat_wr = 1; stat_wdata = 1;
                    tick("R4 clear");
                    quiet(); pulse_event((st + sp + en) % 3);
                    tick("R2 R7 R8 event");
                    quiet();
                    tick("R3 sticky");
                    stat_wr = 1; stat_wdata = 0;
                    tick("R4 write zero");
                    quiet(); pulse_event((st + sp) % 3); stat_wr = 1; stat_wdata = 1;
                    tick("R5 collide");
                    quiet(); stat_wr = 1; stat_wdata = 1;
                    tick("R4 final clear");
                end
            end
        end

        // Random phase: every input toggles each cycle
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom();
            evt_magic  = (r[3:0] == 4'd0);
            evt_link   = (r[7:4] == 4'd0);
            evt_frame  = (r[11:8] == 4'd0);
            stat_wr    = (r[14:12] == 3'd0);
            stat_wdata = r[15];
            pwr_state  = r[18:16];
            support    = r[23:19];
            dev_en     = (r[25:24] != 2'd0);
            bus_en     = (r[27:26] != 2'd0);
            tick("R3 R6 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule